// File: doc/BRIEF.md
# 4B/5B Receive Stream Decoder

This block sits in a 100 Mb/s receive path. Its input is a stream of 5-bit code groups that are already aligned, one group per receive clock. Its output is a nibble interface made of a 4-bit data bus, a data-valid strobe and an error strobe. All three outputs are registered, so each output value describes the code group sampled at the previous clock edge.

While the line is idle, the block hunts for a possible carrier. It confirms a frame only when the start-of-stream delimiter pair arrives, and then turns data code groups into nibbles until the end-of-stream pair. Along the way it reports these events on the strobes:
- invalid code groups;
- loss of the receive signal or of PLL lock;
- an early return to idle;
- false carriers.

A sticky status flag records invalid code groups seen inside a frame and clears when it is read.

Top module: `rxdec_4b5b_rx`

## Requirements
- R1: While reset is high and after it is released, rx_dv, rx_er, rxd and bad_sym_flag are all 0 until a carrier is confirmed.
- R2: In the hunt state, the window is the previous code group followed by the current one, with the previous group's MSB sent first. A carrier is suspected only when this window holds two zero bits that are not neighbours, and only when sig_ok and pll_lock are both high. Anything else leaves all outputs at 0. This includes runs of 11111, a single zero and one adjacent zero pair.
- R3: The code group that raised the suspicion is the first of a pair. If that group is J (11000) and the next is K (10001), the output after K shows rx_dv=1, rx_er=0 and rxd=0101.
- R4: If the suspected pair is not J then K, the output after the second group shows rx_er=1, rx_dv=0 and rxd=1110 for exactly one cycle. The block then goes back to hunting.
- R5: Inside a frame, each of the 16 data code groups gives rx_dv=1, rx_er=0 and its nibble on rxd, one cycle later. rxd[3] is the MSB. The mapping from nibble 0 to F is: 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R6: Inside a frame, a code group that is not data, not T (01101) and not idle (11111) gives rx_dv=1, rx_er=1 and rxd=0000. The frame continues.
- R7: Inside a frame, T gives an output of all zeros, so rx_dv drops. If R (00111) follows, the output stays quiet. Any other group after T gives rx_er=1, rx_dv=0 and rxd=0000 for one cycle. Either way the block returns to hunting.
- R8: Inside a frame, sig_ok=0 or pll_lock=0 gives rx_dv=1, rx_er=1 and rxd=0000 for that group, whatever its code. rx_dv is 0 on the following output and the block hunts again.
- R9: Inside a frame, an idle group 11111 that arrives without T/R gives rx_dv=1, rx_er=1 and rxd=0000. The block then hunts again.
- R10: bad_sym_flag goes to 1 on the output after any R6 event. It goes to 0 on the output after a stat_rd=1 cycle that has no new R6 event. If both happen in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_code | input | 5 | Aligned code group, MSB sent first |
| sig_ok | input | 1 | Receive signal present |
| pll_lock | input | 1 | Clock recovery locked |
| stat_rd | input | 1 | Read strobe for the sticky flag (clear on read) |
| rx_dv | output | 1 | Nibble data valid |
| rx_er | output | 1 | Receive error strobe |
| rxd | output | 4 | Receive nibble, bit 3 MSB |
| bad_sym_flag | output | 1 | Sticky invalid-symbol status |

## Verification
The carrier and delimiter logic is swept over all 1024 ordered pairs of code groups that follow idle. This separates four outcomes: windows with adjacent zeros that stay quiet, true J/K starts, false carriers, and starts whose zeros straddle two groups. Each of the 32 codes is also injected as the first group of a frame and followed by T/R. This separates data decoding from invalid-symbol errors, from early idle and from a broken end-of-stream pair. Separate runs drop sig_ok or pll_lock in mid-frame, and during hunting. Further runs exercise the read and set ordering of the sticky flag.

// File: rtl/rxdec_pkg.sv
package rxdec_pkg;

  localparam logic [4:0] SYM_J    = 5'b11000;
  localparam logic [4:0] SYM_K    = 5'b10001;
  localparam logic [4:0] SYM_T    = 5'b01101;
  localparam logic [4:0] SYM_R    = 5'b00111;
  localparam logic [4:0] SYM_IDLE = 5'b11111;

  localparam logic [3:0] NIB_PREAMBLE = 4'b0101;
  localparam logic [3:0] NIB_FALSE_CS = 4'b1110;

  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_PAIR = 2'd1,
    ST_DATA = 2'd2,
    ST_TAIL = 2'd3
  } rx_state_e;

  // Code group carrying a given data nibble
  function automatic logic [4:0] data_code(input logic [3:0] n);
    case (n)
      4'h0: data_code = 5'b11110;
      4'h1: data_code = 5'b01001;
      4'h2: data_code = 5'b10100;
      4'h3: data_code = 5'b10101;
      4'h4: data_code = 5'b01010;
      4'h5: data_code = 5'b01011;
      4'h6: data_code = 5'b01110;
      4'h7: data_code = 5'b01111;
      4'h8: data_code = 5'b10010;
      4'h9: data_code = 5'b10011;
      4'hA: data_code = 5'b10110;
      4'hB: data_code = 5'b10111;
      4'hC: data_code = 5'b11010;
      4'hD: data_code = 5'b11011;
      4'hE: data_code = 5'b11100;
      default: data_code = 5'b11101;
    endcase
  endfunction

endpackage

// File: rtl/rxdec_sym_map.sv
module rxdec_sym_map
  import rxdec_pkg::*;
#(
  parameter int SYM_W = 5,
  parameter int NIB_W = 4
) (
  input  logic [SYM_W-1:0] code,
  output logic             is_data,
  output logic [NIB_W-1:0] nib,
  output logic             is_j,
  output logic             is_k,
  output logic             is_t,
  output logic             is_r,
  output logic             is_idle
);

  localparam int NUM_DATA = 1 << NIB_W;

  always_comb begin
    is_data = 1'b0;
    nib     = '0;
    for (int n = 0; n < NUM_DATA; n++) begin
      if (code == SYM_W'(data_code(4'(n)))) begin
        is_data = 1'b1;
        nib     = NIB_W'(n);
      end
    end
  end

  assign is_j    = (code == SYM_W'(SYM_J));
  assign is_k    = (code == SYM_W'(SYM_K));
  assign is_t    = (code == SYM_W'(SYM_T));
  assign is_r    = (code == SYM_W'(SYM_R));
  assign is_idle = (code == SYM_W'(SYM_IDLE));

  // R5: a code group falls into at most one class
  always_comb begin
    p_class_onehot_r5: assert ($onehot0({is_data, is_j, is_k, is_t, is_r, is_idle}));
  end

endmodule

// File: rtl/rxdec_carrier_det.sv
module rxdec_carrier_det #(
  parameter int SYM_W    = 5,
  parameter int WIN_SYMS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SYM_W-1:0] code,
  output logic             suspect
);

  localparam int WIN_W  = SYM_W * WIN_SYMS;
  localparam int HIST_W = WIN_W - SYM_W;

  logic [HIST_W-1:0] hist_q;
  logic [WIN_W-1:0]  win;
  logic [WIN_W-1:0]  zeros;
  logic [WIN_W-3:0]  pair_hit;

  assign win   = {hist_q, code};
  assign zeros = ~win;

  always_ff @(posedge clk) begin
    if (rst) hist_q <= '1;
    else     hist_q <= win[HIST_W-1:0];
  end

  // A zero at bit i with another zero two or more places above it
  for (genvar i = 0; i < WIN_W - 2; i++) begin : g_gap
    assign pair_hit[i] = zeros[i] & (|zeros[WIN_W-1:i+2]);
  end

  assign suspect = |pair_hit;

  // R2: a window of at most one zero never raises a suspicion
  p_lone_zero_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    ($countones(zeros) < 2) |-> !suspect);

endmodule

// File: rtl/rxdec_sym_status.sv
module rxdec_sym_status (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic rd,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (rd)  flag <= 1'b0;
  end

  p_sticky_set_r10: assert property (@(posedge clk) disable iff (rst)
    set |=> flag);

  p_sticky_clear_r10: assert property (@(posedge clk) disable iff (rst)
    (rd && !set) |=> !flag);

endmodule

// File: rtl/rxdec_frame_fsm.sv
module rxdec_frame_fsm
  import rxdec_pkg::*;
#(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             link_ok,
  input  logic             suspect,
  input  logic             is_data,
  input  logic [NIB_W-1:0] nib,
  input  logic             is_j,
  input  logic             is_k,
  input  logic             is_t,
  input  logic             is_r,
  input  logic             is_idle,
  output logic             rx_dv,
  output logic             rx_er,
  output logic [NIB_W-1:0] rxd,
  output logic             bad_sym
);

  rx_state_e        st_q, st_d;
  logic             first_j_q, first_j_d;
  logic             dv_d, er_d;
  logic [NIB_W-1:0] nib_d;

  always_comb begin
    st_d      = st_q;
    first_j_d = first_j_q;
    dv_d      = 1'b0;
    er_d      = 1'b0;
    nib_d     = '0;
    bad_sym   = 1'b0;
    case (st_q)
      ST_HUNT: begin
        if (link_ok && suspect) begin
          st_d      = ST_PAIR;
          first_j_d = is_j;
        end
      end
      ST_PAIR: begin
        if (first_j_q && is_k) begin
          st_d  = ST_DATA;
          dv_d  = 1'b1;
          nib_d = NIB_W'(NIB_PREAMBLE);
        end else begin
          st_d  = ST_HUNT;
          er_d  = 1'b1;
          nib_d = NIB_W'(NIB_FALSE_CS);
        end
      end
      ST_DATA: begin
        if (!link_ok) begin
          st_d = ST_HUNT;
          dv_d = 1'b1;
          er_d = 1'b1;
        end else if (is_t) begin
          st_d = ST_TAIL;
        end else if (is_idle) begin
          st_d = ST_HUNT;
          dv_d = 1'b1;
          er_d = 1'b1;
        end else if (is_data) begin
          dv_d  = 1'b1;
          nib_d = nib;
        end else begin
          dv_d    = 1'b1;
          er_d    = 1'b1;
          bad_sym = 1'b1;
        end
      end
      default: begin
        st_d = ST_HUNT;
        er_d = !is_r;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_HUNT;
      first_j_q <= 1'b0;
      rx_dv     <= 1'b0;
      rx_er     <= 1'b0;
      rxd       <= '0;
    end else begin
      st_q      <= st_d;
      first_j_q <= first_j_d;
      rx_dv     <= dv_d;
      rx_er     <= er_d;
      rxd       <= nib_d;
    end
  end

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!rx_dv && !rx_er && rxd == '0));

  p_preamble_on_rise_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(rx_dv) |-> (rxd == NIB_W'(NIB_PREAMBLE) && !rx_er));

  p_fc_back_to_hunt_r4: assert property (@(posedge clk) disable iff (rst)
    (rx_er && !rx_dv && rxd == NIB_W'(NIB_FALSE_CS)) |=> !rx_dv);

  p_err_nibble_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_dv && rx_er) |-> (rxd == '0));

  p_link_loss_ends_r8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_DATA && !link_ok) |=> (rx_dv && rx_er) ##1 !rx_dv);

endmodule

// File: rtl/rxdec_4b5b_rx.sv
module rxdec_4b5b_rx #(
  parameter int SYM_W    = 5,
  parameter int NIB_W    = 4,
  parameter int WIN_SYMS = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SYM_W-1:0] rx_code,
  input  logic             sig_ok,
  input  logic             pll_lock,
  input  logic             stat_rd,
  output logic             rx_dv,
  output logic             rx_er,
  output logic [NIB_W-1:0] rxd,
  output logic             bad_sym_flag
);

  logic             suspect;
  logic             is_data, is_j, is_k, is_t, is_r, is_idle;
  logic [NIB_W-1:0] nib;
  logic             bad_sym;
  logic             link_ok;

  assign link_ok = sig_ok & pll_lock;

  rxdec_sym_map #(.SYM_W(SYM_W), .NIB_W(NIB_W)) u_map (
    .code    (rx_code),
    .is_data (is_data),
    .nib     (nib),
    .is_j    (is_j),
    .is_k    (is_k),
    .is_t    (is_t),
    .is_r    (is_r),
    .is_idle (is_idle)
  );

  rxdec_carrier_det #(.SYM_W(SYM_W), .WIN_SYMS(WIN_SYMS)) u_cdet (
    .clk     (clk),
    .rst     (rst),
    .code    (rx_code),
    .suspect (suspect)
  );

  rxdec_frame_fsm #(.NIB_W(NIB_W)) u_fsm (
    .clk     (clk),
    .rst     (rst),
    .link_ok (link_ok),
    .suspect (suspect),
    .is_data (is_data),
    .nib     (nib),
    .is_j    (is_j),
    .is_k    (is_k),
    .is_t    (is_t),
    .is_r    (is_r),
    .is_idle (is_idle),
    .rx_dv   (rx_dv),
    .rx_er   (rx_er),
    .rxd     (rxd),
    .bad_sym (bad_sym)
  );

  rxdec_sym_status u_stat (
    .clk  (clk),
    .rst  (rst),
    .set  (bad_sym),
    .rd   (stat_rd),
    .flag (bad_sym_flag)
  );

endmodule

// File: tb/rxdec_4b5b_rx_tb.sv
`timescale 1ns/1ps
module rxdec_4b5b_rx_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] rx_code = 5'b11111;
  logic       sig_ok = 1'b1;
  logic       pll_lock = 1'b1;
  logic       stat_rd = 1'b0;
  logic       rx_dv, rx_er, bad_sym_flag;
  logic [3:0] rxd;

  int n_checks = 0;
  int n_errors = 0;

  always #2.5 clk = ~clk;

  rxdec_4b5b_rx u_dut (
    .clk(clk), .rst(rst), .rx_code(rx_code), .sig_ok(sig_ok),
    .pll_lock(pll_lock), .stat_rd(stat_rd), .rx_dv(rx_dv), .rx_er(rx_er),
    .rxd(rxd), .bad_sym_flag(bad_sym_flag)
  );

  localparam logic [4:0] CJ = 5'b11000, CK = 5'b10001, CT = 5'b01101;
  localparam logic [4:0] CR = 5'b00111, CI = 5'b11111;

  // Expected-behaviour model state: 0 hunt, 1 pair, 2 frame, 3 tail
  int         m_st = 0;
  logic [4:0] m_prev = CI;
  logic [4:0] m_first = CI;
  logic       m_flag = 1'b0;

  function automatic logic lookup(input logic [4:0] c, output logic [3:0] n);
    logic [4:0] tbl [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                             5'b01010, 5'b01011, 5'b01110, 5'b01111,
                             5'b10010, 5'b10011, 5'b10110, 5'b10111,
                             5'b11010, 5'b11011, 5'b11100, 5'b11101};
    n = 4'h0;
    for (int k = 0; k < 16; k++) if (tbl[k] == c) begin n = 4'(k); return 1'b1; end
    return 1'b0;
  endfunction

  function automatic logic gap_zeros(input logic [9:0] w);
    int lo = -1, hi = -1;
    for (int b = 0; b < 10; b++) if (!w[b]) begin if (lo < 0) lo = b; hi = b; end
    return (lo >= 0) && (hi - lo >= 2);
  endfunction

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: {dv,er,rxd} actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input logic [4:0] c, input logic s_ok, input logic p_ok, input logic rd);
    logic       ok, dv, er, bad;
    logic [3:0] nv, nb;
    string      req;
    @(negedge clk);
    rx_code = c; sig_ok = s_ok; pll_lock = p_ok; stat_rd = rd;
    @(posedge clk);
    ok = s_ok & p_ok; dv = 0; er = 0; nv = 4'h0; bad = 0; req = "R2";
    case (m_st)
      0: if (ok && gap_zeros({m_prev, c})) begin m_st = 1; m_first = c; end
      1: if (m_first == CJ && c == CK) begin m_st = 2; dv = 1; nv = 4'b0101; req = "R3"; end
         else begin m_st = 0; er = 1; nv = 4'b1110; req = "R4"; end
      2: begin
        if (!ok) begin m_st = 0; dv = 1; er = 1; req = "R8"; end
        else if (c == CT) begin m_st = 3; req = "R7"; end
        else if (c == CI) begin m_st = 0; dv = 1; er = 1; req = "R9"; end
        else if (lookup(c, nb)) begin dv = 1; nv = nb; req = "R5"; end
        else begin dv = 1; er = 1; bad = 1; req = "R6"; end
      end
      default: begin m_st = 0; er = (c != CR); req = "R7"; end
    endcase
    m_prev = c;
    m_flag = bad ? 1'b1 : (rd ? 1'b0 : m_flag);
    #1;
    check(req, {rx_dv, rx_er, rxd}, {dv, er, nv});
    n_checks++;
    if (bad_sym_flag !== m_flag) begin
      n_errors++;
      $display("FAIL R10: bad_sym_flag actual %b expected %b", bad_sym_flag, m_flag);
    end
  endtask

  task automatic sym(input logic [4:0] c);
    step(c, 1'b1, 1'b1, 1'b0);
  endtask

  initial begin
    #(5.0 * 150000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1", {rx_dv, rx_er, rxd}, 6'b0);
    @(negedge clk); rst = 1'b0;
    sym(CI); sym(CI);

    // R2/R3/R4: every ordered pair after idle
    for (int a = 0; a < 32; a++) begin
      for (int b = 0; b < 32; b++) begin
        sym(CI); sym(5'(a)); sym(5'(b)); sym(CI); sym(CI); sym(CI);
      end
    end

    // R5/R6/R7/R9: each code as first frame group, then T/R
    for (int c = 0; c < 32; c++) begin
      sym(CI); sym(CJ); sym(CK); sym(5'(c)); sym(CT); sym(CR); sym(CI); sym(CI);
    end

    // R7: T followed by a non-R group
    sym(CJ); sym(CK); sym(5'b10100); sym(CT); sym(5'b01001); sym(CI);

    // R8: signal loss and PLL unlock in mid-frame
    sym(CJ); sym(CK); sym(5'b01010); step(5'b01010, 1'b0, 1'b1, 1'b0); sym(CI); sym(CI);
    sym(CJ); sym(CK); step(5'b11101, 1'b1, 1'b0, 1'b0); sym(5'b11101); sym(CI); sym(CI);
    // R2: a start pattern is ignored while the link is bad
    step(CJ, 1'b0, 1'b1, 1'b0); step(CK, 1'b0, 1'b1, 1'b0); sym(CI); sym(CI);
    step(CJ, 1'b1, 1'b0, 1'b0); step(CK, 1'b1, 1'b0, 1'b0); sym(CI); sym(CI);

    // R10: read clears the flag, a same-cycle set wins over the read
    step(CI, 1'b1, 1'b1, 1'b1);
    sym(CJ); sym(CK); sym(5'b00010); sym(5'b01011);
    step(5'b01011, 1'b1, 1'b1, 1'b1);
    sym(5'b00011);
    step(5'b00101, 1'b1, 1'b1, 1'b1);
    step(5'b11110, 1'b1, 1'b1, 1'b1);
    sym(CT); sym(CR); sym(CI);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule